// File: doc/BRIEF.md
# H-Bridge Fault Protection Controller

This block holds the control and protection logic for a four-switch H-bridge. Software writes an enable bit, an interrupt enable bit and a set of drive bits: two leg levels, a direction swap and a PWM gating select. The block turns these bits, together with two PWM lines, into the gate-drive enables of the upper and lower switch on each leg. It watches one overcurrent detector per switch and a single overtemperature detector.

A detected fault latches a read-only flag. Only dropping the enable bit clears it. While a flag is set, drive writes are refused. An overcurrent switches off the offending switch after a programmable delay. An overtemperature switches off the whole bridge at once. Either flag can raise an interrupt request, and the request stays up until software clears the enable bit.

Top module: `hbridge_guard`

## Requirements
- R1: After reset all four drive outputs, both fault flags and the interrupt request are 0, and the bridge is disabled.
- R2: While the enable bit is 0, all four drive outputs are 0 whatever the drive bits and PWM lines are.
- R3: With the bridge enabled and no fault, drive bit 0 is the left upper switch, bit 1 the left lower, bit 2 the right upper and bit 3 the right lower. A leg level of 1 turns that leg's upper switch on and its lower switch off. A level of 0 does the reverse. The left leg takes the first level bit and the right leg the second. Setting the direction bit swaps them.
- R4: With PWM gating selected, each upper switch is further ANDed with its leg's PWM line: the first PWM line for the left leg, the second for the right. The lower switches are not gated.
- R5: The short-circuit flag is the OR of the four overcurrent inputs. It sets on the clock edge at which any of them is high while the bridge is enabled.
- R6: A switch whose overcurrent input was high while the short-circuit flag was rising or set is turned off SC_DELAY+1 clock edges after the edge that set the flag. Switches that saw no overcurrent keep following their drive decode.
- R7: The overtemperature flag sets on the edge at which the temperature input is high while enabled. From that edge on, all four drive outputs are 0.
- R8: Both flags are sticky. Removing the fault input does not clear them, and drive writes made while either flag is set are ignored. Only a write of 0 to the enable bit clears them, on that write's edge.
- R9: When the interrupt enable bit is 1, the edge that sets either flag also sets the interrupt request.
- R10: Writing the interrupt enable bit from 0 to 1 while a flag is set raises the interrupt request on that write's edge.
- R11: The interrupt request stays set until the enable bit is written to 0, which clears it. After re-enabling with the fault input still high, the flag and the request set again.
- R12: The upper and lower switch of the same leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_stb | input | 1 | Write strobe for the enable bit |
| wr_en_val | input | 1 | Enable value to write |
| wr_ie_stb | input | 1 | Write strobe for the interrupt enable bit |
| wr_ie_val | input | 1 | Interrupt enable value to write |
| wr_drv_stb | input | 1 | Write strobe for the drive bits |
| wr_lvl_a | input | 1 | First leg level bit |
| wr_lvl_b | input | 1 | Second leg level bit |
| wr_swap | input | 1 | Direction swap bit |
| wr_pwm_sel | input | 1 | PWM gating select |
| pwm_a | input | 1 | PWM line for the left leg |
| pwm_b | input | 1 | PWM line for the right leg |
| oc_det | input | 4 | Per-switch overcurrent detectors, same bit order as drv |
| ot_det | input | 1 | Overtemperature detector |
| drv | output | 4 | Switch drive enables, 1 = on |
| sc_flag | output | 1 | Latched short-circuit flag |
| ot_flag | output | 1 | Latched overtemperature flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two copies that share every input. The main copy uses SC_DELAY=3, so the switch cut-off can be timed edge by edge and checked to be neither early nor late. The second copy uses SC_DELAY=0, which covers the boundary where the cut-off lands on the very next edge. Both copies see the same fault, so the two delay settings are compared under identical stimulus.

// File: rtl/hbg_pkg.sv
// Package: shared drive-mode type and switch index constants for the
// H-bridge guard. Assumes a two-leg, four-switch bridge.
package hbg_pkg;

    localparam int NUM_LEGS = 2;
    localparam int NUM_SW   = 2 * NUM_LEGS;

    // Switch positions in the drive / detector vectors
    localparam int SW_LU = 0;
    localparam int SW_LD = 1;
    localparam int SW_RU = 2;
    localparam int SW_RD = 3;

    typedef struct packed {
        logic lvl_a;
        logic lvl_b;
        logic swap;
        logic pwm_sel;
    } hbg_mode_t;

endpackage

// File: rtl/hbg_regs.sv
// Control register file: holds the enable, interrupt enable and drive
// mode bits written through strobes. Drive writes are refused while a
// fault is latched. Assumes strobes are single-cycle synchronous pulses.
module hbg_regs
    import hbg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en_stb,
    input  logic      wr_en_val,
    input  logic      wr_ie_stb,
    input  logic      wr_ie_val,
    input  logic      wr_drv_stb,
    input  hbg_mode_t wr_mode,
    input  logic      fault_any,
    output logic      en_q,
    output logic      en_live,
    output logic      ie_q,
    output logic      ie_rise,
    output hbg_mode_t mode_q
);

    // Enable bit still high after this cycle's write
    assign en_live = en_q && !(wr_en_stb && !wr_en_val);
    // Interrupt enable going from 0 to 1 on this edge
    assign ie_rise = wr_ie_stb && wr_ie_val && !ie_q;

    // Enable and interrupt enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            ie_q <= 1'b0;
        end else begin
            if (wr_en_stb) en_q <= wr_en_val;
            if (wr_ie_stb) ie_q <= wr_ie_val;
        end
    end

    // Drive mode register, frozen while a fault flag is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_drv_stb && !fault_any) begin
            mode_q <= wr_mode;
        end
    end

endmodule

// File: rtl/hbg_fault.sv
// Fault latch: sticky short-circuit and overtemperature flags, plus the
// per-switch cut-off mask released SC_DELAY+1 edges after the
// short-circuit flag sets. Everything clears when enable drops.
module hbg_fault
    import hbg_pkg::*;
#(
    parameter int SC_DELAY = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_live,
    input  logic [NUM_SW-1:0] oc_det,
    input  logic              ot_det,
    output logic              sc_flag,
    output logic              ot_flag,
    output logic              sc_set,
    output logic              ot_set,
    output logic [NUM_SW-1:0] cut_mask
);

    localparam int CW = (SC_DELAY < 1) ? 1 : $clog2(SC_DELAY + 1);
    localparam logic [CW-1:0] LOAD = CW'(SC_DELAY);

    logic              oc_any;
    logic [CW-1:0]     dly_cnt;
    logic              dly_armed;
    logic [NUM_SW-1:0] oc_seen;

    assign oc_any = |oc_det;
    assign sc_set = en_live && oc_any && !sc_flag;
    assign ot_set = en_live && ot_det && !ot_flag;

    // Sticky fault flags, cleared only while enable is low
    always_ff @(posedge clk) begin
        if (!rst_n || !en_live) begin
            sc_flag <= 1'b0;
            ot_flag <= 1'b0;
        end else begin
            if (oc_any) sc_flag <= 1'b1;
            if (ot_det) ot_flag <= 1'b1;
        end
    end

    // Cut-off delay counter and collection of overcurrent switches
    always_ff @(posedge clk) begin
        if (!rst_n || !en_live) begin
            dly_cnt   <= '0;
            dly_armed <= 1'b0;
            oc_seen   <= '0;
            cut_mask  <= '0;
        end else if (sc_set) begin
            dly_cnt   <= LOAD;
            dly_armed <= 1'b1;
            oc_seen   <= oc_det;
        end else if (sc_flag) begin
            oc_seen <= oc_seen | oc_det;
            if (dly_armed) begin
                if (dly_cnt == '0) begin
                    dly_armed <= 1'b0;
                    cut_mask  <= oc_seen | oc_det;
                end else begin
                    dly_cnt <= dly_cnt - 1'b1;
                end
            end else begin
                cut_mask <= cut_mask | oc_det;
            end
        end
    end

endmodule

// File: rtl/hbg_drive.sv
// Drive decode: turns the mode bits and PWM lines into the four switch
// enables, then applies enable, overtemperature and per-switch cut-off
// forcing. Assumes one upper and one lower switch per leg.
module hbg_drive
    import hbg_pkg::*;
(
    input  hbg_mode_t         mode_q,
    input  logic              en_q,
    input  logic              ot_flag,
    input  logic [NUM_SW-1:0] cut_mask,
    input  logic              pwm_a,
    input  logic              pwm_b,
    output logic [NUM_SW-1:0] drv
);

    logic bridge_on;
    assign bridge_on = en_q && !ot_flag;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        logic lvl;
        logic pwm;
        logic up;
        logic dn;
        // Leg level after the direction swap
        always_comb begin
            if (g == 0) lvl = mode_q.swap ? mode_q.lvl_b : mode_q.lvl_a;
            else        lvl = mode_q.swap ? mode_q.lvl_a : mode_q.lvl_b;
            pwm = (g == 0) ? pwm_a : pwm_b;
        end
        // Upper/lower request with optional PWM gating on the upper switch
        assign up = lvl && (!mode_q.pwm_sel || pwm);
        assign dn = !lvl;
        assign drv[2*g]   = bridge_on && up && !cut_mask[2*g];
        assign drv[2*g+1] = bridge_on && dn && !cut_mask[2*g+1];
    end

endmodule

// File: rtl/hbg_irq.sv
// Interrupt request latch: set by a flag's rising edge when enabled, or
// by enabling interrupts while a flag is set; cleared only with enable.
module hbg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic en_live,
    input  logic ie_q,
    input  logic ie_rise,
    input  logic sc_set,
    input  logic ot_set,
    input  logic sc_flag,
    input  logic ot_flag,
    output logic irq
);

    // Request latch
    always_ff @(posedge clk) begin
        if (!rst_n || !en_live) begin
            irq <= 1'b0;
        end else if ((ie_q || ie_rise) && (sc_set || ot_set)) begin
            irq <= 1'b1;
        end else if (ie_rise && (sc_flag || ot_flag)) begin
            irq <= 1'b1;
        end
    end

endmodule

// File: rtl/hbridge_guard.sv
// Top: H-bridge control and protection. Ties together the register file,
// fault latch, drive decode and interrupt latch. SC_DELAY is the
// overcurrent cut-off delay in clock cycles (0 = next edge).
module hbridge_guard
    import hbg_pkg::*;
#(
    parameter int SC_DELAY = 8
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_stb,
    input  logic       wr_en_val,
    input  logic       wr_ie_stb,
    input  logic       wr_ie_val,
    input  logic       wr_drv_stb,
    input  logic       wr_lvl_a,
    input  logic       wr_lvl_b,
    input  logic       wr_swap,
    input  logic       wr_pwm_sel,
    input  logic       pwm_a,
    input  logic       pwm_b,
    input  logic [3:0] oc_det,
    input  logic       ot_det,
    output logic [3:0] drv,
    output logic       sc_flag,
    output logic       ot_flag,
    output logic       irq
);

    hbg_mode_t         wr_mode;
    hbg_mode_t         mode_q;
    logic              en_q;
    logic              en_live;
    logic              ie_q;
    logic              ie_rise;
    logic              sc_set;
    logic              ot_set;
    logic [NUM_SW-1:0] cut_mask;

    assign wr_mode = '{lvl_a: wr_lvl_a, lvl_b: wr_lvl_b,
                       swap: wr_swap, pwm_sel: wr_pwm_sel};

    hbg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_stb  (wr_en_stb),
        .wr_en_val  (wr_en_val),
        .wr_ie_stb  (wr_ie_stb),
        .wr_ie_val  (wr_ie_val),
        .wr_drv_stb (wr_drv_stb),
        .wr_mode    (wr_mode),
        .fault_any  (sc_flag || ot_flag),
        .en_q       (en_q),
        .en_live    (en_live),
        .ie_q       (ie_q),
        .ie_rise    (ie_rise),
        .mode_q     (mode_q)
    );

    hbg_fault #(.SC_DELAY(SC_DELAY)) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_live  (en_live),
        .oc_det   (oc_det),
        .ot_det   (ot_det),
        .sc_flag  (sc_flag),
        .ot_flag  (ot_flag),
        .sc_set   (sc_set),
        .ot_set   (ot_set),
        .cut_mask (cut_mask)
    );

    hbg_drive u_drive (
        .mode_q   (mode_q),
        .en_q     (en_q),
        .ot_flag  (ot_flag),
        .cut_mask (cut_mask),
        .pwm_a    (pwm_a),
        .pwm_b    (pwm_b),
        .drv      (drv)
    );

    hbg_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_live (en_live),
        .ie_q    (ie_q),
        .ie_rise (ie_rise),
        .sc_set  (sc_set),
        .ot_set  (ot_set),
        .sc_flag (sc_flag),
        .ot_flag (ot_flag),
        .irq     (irq)
    );

endmodule

// File: rtl/hbg_checker.sv
// Checker: temporal properties of the H-bridge guard, bound to the top.
module hbg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_stb,
    input logic       wr_en_val,
    input logic [3:0] oc_det,
    input logic [3:0] drv,
    input logic       sc_flag,
    input logic       ot_flag,
    input logic       irq,
    input logic       en_q
);

    // R12: never both switches of one leg on
    assert_no_shoot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv[0] && drv[1]) && !(drv[2] && drv[3]));

    // R2: disabled bridge drives nothing
    assert_en_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> drv == 4'b0000);

    // R7: overtemperature forces all switches off
    assert_ot_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |-> drv == 4'b0000);

    // R8: flags stay set unless enable is written to 0
    assert_sc_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_flag && !(wr_en_stb && !wr_en_val)) |=> sc_flag);
    assert_ot_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag && !(wr_en_stb && !wr_en_val)) |=> ot_flag);

    // R5: short-circuit flag rises only after an overcurrent input
    assert_sc_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sc_flag) |-> $past(|oc_det));

    // R11: clearing enable drops the request
    assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_stb && !wr_en_val) |=> !irq);

    // R9: a request only exists with a flag set
    assert_irq_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sc_flag || ot_flag));

endmodule

bind hbridge_guard hbg_checker u_hbg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_stb (wr_en_stb),
    .wr_en_val (wr_en_val),
    .oc_det    (oc_det),
    .drv       (drv),
    .sc_flag   (sc_flag),
    .ot_flag   (ot_flag),
    .irq       (irq),
    .en_q      (en_q)
);

// File: tb/test_hbridge_guard.sv
module test_hbridge_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_stb = 0, wr_en_val = 0;
    logic       wr_ie_stb = 0, wr_ie_val = 0;
    logic       wr_drv_stb = 0, wr_lvl_a = 0, wr_lvl_b = 0, wr_swap = 0, wr_pwm_sel = 0;
    logic       pwm_a = 0, pwm_b = 0;
    logic [3:0] oc_det = 4'b0;
    logic       ot_det = 0;
    logic [3:0] drv, drv_z;
    logic       sc_flag, ot_flag, irq;
    logic       sc_z, ot_z, irq_z;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    hbridge_guard #(.SC_DELAY(3)) i_hbridge_guard (
        .clk(clk), .rst_n(rst_n),
        .wr_en_stb(wr_en_stb), .wr_en_val(wr_en_val),
        .wr_ie_stb(wr_ie_stb), .wr_ie_val(wr_ie_val),
        .wr_drv_stb(wr_drv_stb), .wr_lvl_a(wr_lvl_a), .wr_lvl_b(wr_lvl_b),
        .wr_swap(wr_swap), .wr_pwm_sel(wr_pwm_sel),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .oc_det(oc_det), .ot_det(ot_det),
        .drv(drv), .sc_flag(sc_flag), .ot_flag(ot_flag), .irq(irq)
    );

    hbridge_guard #(.SC_DELAY(0)) i_hbridge_guard_z (
        .clk(clk), .rst_n(rst_n),
        .wr_en_stb(wr_en_stb), .wr_en_val(wr_en_val),
        .wr_ie_stb(wr_ie_stb), .wr_ie_val(wr_ie_val),
        .wr_drv_stb(wr_drv_stb), .wr_lvl_a(wr_lvl_a), .wr_lvl_b(wr_lvl_b),
        .wr_swap(wr_swap), .wr_pwm_sel(wr_pwm_sel),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .oc_det(oc_det), .ot_det(ot_det),
        .drv(drv_z), .sc_flag(sc_z), .ot_flag(ot_z), .irq(irq_z)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en_stb = 0; wr_ie_stb = 0; wr_drv_stb = 0;
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_en(logic v);
        wr_en_stb = 1; wr_en_val = v; tick();
    endtask

    task automatic set_ie(logic v);
        wr_ie_stb = 1; wr_ie_val = v; tick();
    endtask

    task automatic set_mode(logic a, logic b, logic sw, logic ps);
        wr_drv_stb = 1; wr_lvl_a = a; wr_lvl_b = b; wr_swap = sw; wr_pwm_sel = ps;
        tick();
    endtask

    task automatic t_reset();
        chk("R1", "drv", drv, 4'b0000);
        chk("R1", "sc_flag", sc_flag, 0);
        chk("R1", "ot_flag", ot_flag, 0);
        chk("R1", "irq", irq, 0);
    endtask

    task automatic t_disabled();
        set_mode(1, 0, 0, 0);
        chk("R2", "drv while disabled", drv, 4'b0000);
        oc_det = 4'b0001; tick(); oc_det = 4'b0000;
        chk("R2", "no flag while disabled", sc_flag, 0);
    endtask

    task automatic t_decode();
        set_en(1);
        chk("R3", "a=1 b=0", drv, 4'b1001);
        set_mode(0, 1, 0, 0);
        chk("R3", "a=0 b=1", drv, 4'b0110);
        set_mode(1, 0, 1, 0);
        chk("R3", "swapped a=1 b=0", drv, 4'b0110);
        set_mode(1, 1, 0, 0);
        chk("R3", "both high", drv, 4'b0101);
    endtask

    task automatic t_pwm();
        set_mode(1, 0, 0, 1);
        pwm_a = 0; #1;
        chk("R4", "pwm_a low", drv, 4'b1000);
        pwm_a = 1; #1;
        chk("R4", "pwm_a high", drv, 4'b1001);
        set_mode(0, 1, 0, 1);
        pwm_b = 0; #1;
        chk("R4", "pwm_b low", drv, 4'b0010);
        pwm_b = 1; #1;
        chk("R4", "pwm_b high", drv, 4'b0110);
        set_mode(1, 0, 0, 0);
    endtask

    task automatic t_short();
        set_ie(1);
        chk("R3", "pre-fault", drv, 4'b1001);
        oc_det = 4'b1000; tick();
        chk("R5", "sc set", sc_flag, 1);
        chk("R9", "irq on sc", irq, 1);
        chk("R6", "zero delay still on", drv_z, 4'b1001);
        tick();
        chk("R6", "zero delay cut", drv_z, 4'b0001);
        chk("R6", "delay 3 edge 1", drv, 4'b1001);
        tick(); tick();
        chk("R6", "delay 3 edge 3", drv, 4'b1001);
        tick();
        chk("R6", "delay 3 cut", drv, 4'b0001);
        oc_det = 4'b0000;
        set_mode(0, 1, 0, 0);
        chk("R8", "drive write ignored", drv, 4'b0001);
        tick(); tick();
        chk("R8", "sc sticky", sc_flag, 1);
        chk("R11", "irq held", irq, 1);
        set_en(0);
        chk("R8", "sc cleared", sc_flag, 0);
        chk("R11", "irq cleared", irq, 0);
        oc_det = 4'b0010;
        set_en(1);
        chk("R11", "drive restored", drv, 4'b1001);
        tick();
        chk("R11", "sc sets again", sc_flag, 1);
        chk("R11", "irq again", irq, 1);
        oc_det = 4'b0000;
        set_en(0);
        set_ie(0);
    endtask

    task automatic t_thermal();
        set_en(1);
        chk("R3", "before ot", drv, 4'b1001);
        ot_det = 1; tick();
        chk("R7", "ot set", ot_flag, 1);
        chk("R7", "all off", drv, 4'b0000);
        chk("R9", "no irq when disabled", irq, 0);
        ot_det = 0;
        set_ie(1);
        chk("R10", "irq on late enable", irq, 1);
        chk("R8", "ot sticky", ot_flag, 1);
        set_en(0);
        chk("R8", "ot cleared", ot_flag, 0);
        chk("R11", "irq cleared", irq, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) tick();
                rst_n = 1;
                t_reset();
                t_disabled();
                t_decode();
                t_pwm();
                t_short();
                t_thermal();
                done = 1;
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    n_chk++; n_bad++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule